// File: doc/BRIEF.md
# Adaptive back-to-back transmit gap throttle

This block sits between a transmit frame queue and a CSMA/CD transmit engine and decides the clock cycle in which a waiting frame may start. It watches the transmit and receive activity levels. When either one ends, it loads a down-counter with the required idle gap. When the counter is empty, no activity is in progress and a frame is waiting, it raises a grant.

The gap is counted in transmit-clock periods. A prescaler derives one count per period from a fixed core clock: one count per core cycle at gigabit speed, one per 10 cycles at 100 Mb/s and one per 100 cycles at 10 Mb/s. Every gap is at least a fixed floor of 12 counts, which is the standard minimum spacing at all three speeds. The programmable base gap can lengthen it. A second 16-bit programmable gap, the adaptive stretch, applies only when one of the block's own transmissions is directly followed by a fresh frame. The two programmed values are never added: the larger one wins. Setting the adaptive value to zero gives plain back-to-back spacing.

Top module: `gap_throttle`

## Requirements
- R1: After reset the gap counter is empty, so `tx_grant` rises in the same cycle that `frame_pending` is high, with no activity in progress.
- R2: `link_speed` encodes 0 = 10 Mb/s, 1 = 100 Mb/s, 2 = 1000 Mb/s, and 3 is handled as 1000 Mb/s. One gap count lasts 100, 10 or 1 clock cycles respectively.
- R3: With a loaded gap of L counts and D cycles per count, `tx_grant` stays low for L·D clock edges after the first edge that sees activity low, and rises after edge L·D+1. L is never below 12.
- R4: For a back-to-back transmit, L = max(12, `base_gap`, `adapt_gap`), never their sum.
- R5: A gap is back-to-back when `tx_active` falls, `rx_active` does not fall in the same cycle, `frame_pending` is high and `retry` is low in that cycle.
- R6: A gap that starts at the end of a receive uses L = max(12, `base_gap`) and ignores `adapt_gap`.
- R7: A gap after a transmit where `retry` is high at the falling edge ignores `adapt_gap`.
- R8: A gap after a transmit with no frame pending at the falling edge ignores `adapt_gap`, even if a frame arrives later.
- R9: `tx_grant` is high only when the counter is empty, `frame_pending` is high and neither `tx_active` nor `rx_active` is high.
- R10: `adapt_gap`, `base_gap` and the back-to-back decision are taken when the gap is loaded. Changes made in the middle of a gap do not alter that gap.
- R11: A new end of activity during a gap reloads the counter, and the gap restarts from that point with the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| link_speed | input | 2 | Link speed code (see R2) |
| adapt_gap | input | 16 | Adaptive back-to-back stretch, in gap counts |
| base_gap | input | 16 | Base inter-packet gap, in gap counts |
| tx_active | input | 1 | High while the block's own frame is on the wire |
| rx_active | input | 1 | High while a frame is being received |
| retry | input | 1 | The pending frame is a retransmission after a collision |
| frame_pending | input | 1 | A frame is queued and waiting |
| tx_grant | output | 1 | The queued frame may start now |

## Verification
The bench measures the exact edge on which the grant rises. A throttle that adds the base and adaptive values instead of taking their maximum would grant far too late. A throttle that lets a value below the floor through would grant too early, as 100 Mb/s with an adaptive value of 10 would show. The cases where the stretch must be ignored are a receive end, a retransmission and a transmit end with nothing queued. A design that applied the stretch in any of them would hold the grant low through the expected edge. The bench also changes the gap registers in the middle of a gap, and restarts a gap with a receive burst. A design that reads the registers live, or keeps counting over the new activity, grants at the wrong edge.

// File: rtl/gapthr_pkg.sv
package gapthr_pkg;

    // Link speed code carried on link_speed
    typedef enum logic [1:0] {
        SPD_10M    = 2'd0,
        SPD_100M   = 2'd1,
        SPD_1G     = 2'd2,
        SPD_1G_ALT = 2'd3
    } speed_e;

endpackage

// File: rtl/gapthr_tick.sv
// Prescaler: one enable per transmit-clock period of the current speed.
module gapthr_tick #(
    parameter int DIV_10M  = 100,
    parameter int DIV_100M = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] speed,
    input  logic       restart,
    output logic       tick
);
    import gapthr_pkg::*;

    localparam int PRE_W = $clog2(DIV_10M + 1);

    typedef struct packed {
        logic [PRE_W-1:0] pre;
    } tick_state_t;

    tick_state_t      s_q, s_d;
    logic [PRE_W-1:0] limit;
    logic             wrap;

    always_comb begin
        case (speed_e'(speed))
            SPD_10M:  limit = PRE_W'(DIV_10M - 1);
            SPD_100M: limit = PRE_W'(DIV_100M - 1);
            default:  limit = '0;
        endcase
        wrap = (s_q.pre >= limit);
        tick = !restart && wrap;
        s_d  = s_q;
        if (restart || wrap) begin
            s_d.pre = '0;
        end else begin
            s_d.pre = s_q.pre + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/gapthr_select.sv
// Chooses the gap length to load when activity ends.
module gapthr_select #(
    parameter int CNT_W    = 16,
    parameter int FLOOR    = 12,
    parameter bit ADAPT_EN = 1'b1
) (
    input  logic             tx_fall,
    input  logic             rx_fall,
    input  logic             pending,
    input  logic             retry,
    input  logic [CNT_W-1:0] adapt,
    input  logic [CNT_W-1:0] base,
    output logic [CNT_W-1:0] load_val
);
    localparam logic [CNT_W-1:0] FLOOR_C = CNT_W'(FLOOR);

    logic [CNT_W-1:0] plain_gap;

    always_comb begin
        plain_gap = (base > FLOOR_C) ? base : FLOOR_C;
    end

    generate
        if (ADAPT_EN) begin : g_adapt
            logic back_to_back;
            always_comb begin
                back_to_back = tx_fall && !rx_fall && pending && !retry;
                if (back_to_back && (adapt > plain_gap)) begin
                    load_val = adapt;
                end else begin
                    load_val = plain_gap;
                end
            end
        end else begin : g_plain
            logic unused_ok;
            always_comb begin
                unused_ok = ^{tx_fall, rx_fall, pending, retry, adapt};
                load_val  = plain_gap;
            end
        end
    endgenerate

endmodule

// File: rtl/gap_throttle.sv
module gap_throttle #(
    parameter int CNT_W    = 16,
    parameter int FLOOR    = 12,
    parameter int DIV_10M  = 100,
    parameter int DIV_100M = 10
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  link_speed,
    input  logic [15:0] adapt_gap,
    input  logic [15:0] base_gap,
    input  logic        tx_active,
    input  logic        rx_active,
    input  logic        retry,
    input  logic        frame_pending,
    output logic        tx_grant
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             tx_prev;
        logic             rx_prev;
    } gap_state_t;

    gap_state_t       state_q, state_d;
    logic             tx_fall, rx_fall, load, busy, tick;
    logic [CNT_W-1:0] load_val;
    logic [CNT_W-1:0] cnt_now;

    assign tx_fall = state_q.tx_prev && !tx_active;
    assign rx_fall = state_q.rx_prev && !rx_active;
    assign load    = tx_fall || rx_fall;
    assign busy    = tx_active || rx_active;
    assign cnt_now = state_q.cnt;

    gapthr_tick #(
        .DIV_10M (DIV_10M),
        .DIV_100M(DIV_100M)
    ) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .speed  (link_speed),
        .restart(load || busy),
        .tick   (tick)
    );

    gapthr_select #(
        .CNT_W   (CNT_W),
        .FLOOR   (FLOOR),
        .ADAPT_EN(1'b1)
    ) u_select (
        .tx_fall (tx_fall),
        .rx_fall (rx_fall),
        .pending (frame_pending),
        .retry   (retry),
        .adapt   (CNT_W'(adapt_gap)),
        .base    (CNT_W'(base_gap)),
        .load_val(load_val)
    );

    always_comb begin
        state_d         = state_q;
        state_d.tx_prev = tx_active;
        state_d.rx_prev = rx_active;
        if (load) begin
            state_d.cnt = load_val;
        end else if (!busy && tick && (state_q.cnt != '0)) begin
            state_d.cnt = state_q.cnt - 1'b1;
        end
        tx_grant = (state_q.cnt == '0) && !load && !busy && frame_pending;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

endmodule

// File: rtl/gap_throttle_chk.sv
module gap_throttle_chk #(
    parameter int CNT_W = 16,
    parameter int FLOOR = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tx_active,
    input logic             rx_active,
    input logic             frame_pending,
    input logic             tx_grant,
    input logic             load,
    input logic [CNT_W-1:0] cnt
);
    logic [7:0] idle_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_q <= 8'hFF;
        end else if (tx_active || rx_active) begin
            idle_q <= '0;
        end else if (idle_q != 8'hFF) begin
            idle_q <= idle_q + 1'b1;
        end
    end

    // R9
    grant_needs_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_grant |-> frame_pending);

    // R9
    quiet_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_active || rx_active) |-> !tx_grant);

    // R3
    floor_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_grant |-> (idle_q > 8'(FLOOR)));

    // R11
    count_only_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> (cnt <= $past(cnt)));

endmodule

bind gap_throttle gap_throttle_chk #(
    .CNT_W(CNT_W),
    .FLOOR(FLOOR)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tx_active    (tx_active),
    .rx_active    (rx_active),
    .frame_pending(frame_pending),
    .tx_grant     (tx_grant),
    .load         (load),
    .cnt          (cnt_now)
);

// File: tb/tb_gap_throttle.sv
module tb_gap_throttle;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  link_speed = 2'd2;
    logic [15:0] adapt_gap = '0;
    logic [15:0] base_gap = '0;
    logic        tx_active = 1'b0;
    logic        rx_active = 1'b0;
    logic        retry = 1'b0;
    logic        frame_pending = 1'b0;
    logic        tx_grant;

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    gap_throttle dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .link_speed   (link_speed),
        .adapt_gap    (adapt_gap),
        .base_gap     (base_gap),
        .tx_active    (tx_active),
        .rx_active    (rx_active),
        .retry        (retry),
        .frame_pending(frame_pending),
        .tx_grant     (tx_grant)
    );

    typedef struct packed {
        logic [1:0]  spd;
        logic [15:0] adapt;
        logic [15:0] base;
        logic        from_rx;
        logic        pend_end;
        logic        rtx;
        logic [15:0] expl;
    } vec_t;

    localparam int NVEC = 12;
    localparam vec_t VECS [NVEC] = '{
        '{2'd2, 16'd0,  16'd0,  1'b0, 1'b1, 1'b0, 16'd12},
        '{2'd2, 16'd40, 16'd0,  1'b0, 1'b1, 1'b0, 16'd40},
        '{2'd2, 16'd40, 16'd50, 1'b0, 1'b1, 1'b0, 16'd50},
        '{2'd2, 16'd60, 16'd50, 1'b0, 1'b1, 1'b0, 16'd60},
        '{2'd2, 16'd40, 16'd20, 1'b1, 1'b1, 1'b0, 16'd20},
        '{2'd2, 16'd40, 16'd5,  1'b0, 1'b1, 1'b1, 16'd12},
        '{2'd2, 16'd40, 16'd0,  1'b0, 1'b0, 1'b0, 16'd12},
        '{2'd1, 16'd10, 16'd0,  1'b0, 1'b1, 1'b0, 16'd12},
        '{2'd1, 16'd20, 16'd0,  1'b0, 1'b1, 1'b0, 16'd20},
        '{2'd0, 16'd0,  16'd0,  1'b0, 1'b1, 1'b0, 16'd12},
        '{2'd3, 16'd20, 16'd0,  1'b0, 1'b1, 1'b0, 16'd20},
        '{2'd2, 16'd13, 16'd0,  1'b0, 1'b1, 1'b0, 16'd13}
    };

    function automatic string vec_req(int i);
        case (i)
            0:       return "R3";
            1:       return "R5";
            2, 3:    return "R4";
            4:       return "R6";
            5:       return "R7";
            6:       return "R8";
            7:       return "R3 (100M below floor)";
            default: return "R2";
        endcase
    endfunction

    function automatic int div_of(logic [1:0] s);
        case (s)
            2'd0:    return 100;
            2'd1:    return 10;
            default: return 1;
        endcase
    endfunction

    task automatic chk(string req, logic act, logic exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: tx_grant=%0b expected %0b", req, act, exp);
        end
    endtask

    // Drive one activity burst, then drop it before the next edge.
    task automatic burst(logic [1:0] s, logic [15:0] a, logic [15:0] b,
                         logic from_rx, logic pend_end, logic rtx);
        @(negedge clk);
        link_speed    = s;
        adapt_gap     = a;
        base_gap      = b;
        retry         = rtx;
        frame_pending = pend_end;
        if (from_rx) rx_active = 1'b1;
        else         tx_active = 1'b1;
        @(posedge clk);
        @(negedge clk);
        tx_active = 1'b0;
        rx_active = 1'b0;
    endtask

    // Count edges after the activity drop and check the grant edge.
    task automatic gap_wait(int expl, int d, logic pend_late, string req);
        for (int k = 1; k <= expl * d + 1; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (k == 1 && pend_late) frame_pending = 1'b1;
            if (k == expl * d)     chk(req, tx_grant, 1'b0);
            if (k == expl * d + 1) chk(req, tx_grant, 1'b1);
        end
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: run hung, actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1 idle no pending", tx_grant, 1'b0);
        frame_pending = 1'b1;
        #1;
        chk("R1 grant right after reset", tx_grant, 1'b1);
        // R9: busy or not pending blocks the grant
        frame_pending = 1'b0;
        #1;
        chk("R9 no pending", tx_grant, 1'b0);
        frame_pending = 1'b1;
        rx_active = 1'b1;
        #1;
        chk("R9 receive in progress", tx_grant, 1'b0);
        rx_active = 1'b0;
        tx_active = 1'b1;
        #1;
        chk("R9 transmit in progress", tx_grant, 1'b0);
        tx_active = 1'b0;
        frame_pending = 1'b0;
        repeat (20) @(posedge clk);

        // Table walk
        for (int i = 0; i < NVEC; i++) begin
            burst(VECS[i].spd, VECS[i].adapt, VECS[i].base,
                  VECS[i].from_rx, VECS[i].pend_end, VECS[i].rtx);
            gap_wait(int'(VECS[i].expl), div_of(VECS[i].spd), !VECS[i].pend_end, vec_req(i));
            frame_pending = 1'b0;
            retry = 1'b0;
        end

        // R10: register change mid-gap leaves the running gap alone
        burst(2'd2, 16'd40, 16'd0, 1'b0, 1'b1, 1'b0);
        for (int k = 1; k <= 41; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (k == 5) begin
                adapt_gap = 16'd100;
                base_gap  = 16'd100;
            end
            if (k == 40) chk("R10", tx_grant, 1'b0);
            if (k == 41) chk("R10", tx_grant, 1'b1);
        end
        frame_pending = 1'b0;
        adapt_gap = '0;
        base_gap  = '0;

        // R11: receive burst mid-gap restarts the gap with the plain length
        burst(2'd2, 16'd40, 16'd0, 1'b0, 1'b1, 1'b0);
        repeat (8) begin
            @(posedge clk);
            @(negedge clk);
        end
        rx_active = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rx_active = 1'b0;
        gap_wait(12, 1, 1'b0, "R11");
        frame_pending = 1'b0;
        adapt_gap = '0;

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule